// File: doc/BRIEF.md
# Transverse-Plane Track Fit Corrector

This block refines a seed track in the bending plane. For each seed it takes nine segment angle words, a 10-bit layer hit map and a coarse 6-bit signed curvature. It rescales every angle word with a per-layer constant and adds a per-layer zero offset. It then applies a curvature shift whose sign follows the sign of the curvature. Two weighted sums are built over the layers that are usable for the axial fit. A closed-form solve of multiplies and shifts turns those sums into an angle correction and a refined curvature.

All coefficients live in constant tables set through parameter arrays. A small curvature bin and a usable-layer count select the table entries, so the run-time work is additions, multiplications and arithmetic shifts only. The datapath is fully pipelined. A strobe may arrive on every cycle, and each strobe yields exactly one done pulse a fixed number of cycles later.

Top module: `trk_rphi_fit`

## Requirements
- R1: The curvature bin is min(|rho_in| >> 3, 3), with rho_in read as 6-bit two's complement. It selects every curvature-dependent table entry.
- R2: Layer i (0..8) has a signed 10-bit angle in seg_ang[10i+9:10i]. Its corrected angle is ((angle × CONV_K[i]) >>> 13) + ZERO_K[i] ± CURV_K[4i+bin].
- R3: The curvature term CURV_K is added when rho_in is zero or positive and subtracted when rho_in is negative.
- R4: Hit-map bits 0..5 are three stereo pairs: (0,1), (2,3) and (4,5). Both layers of a pair are usable only when both bits are set. Bits 6..8 are axial layers, each usable when set. The count n is the number of hit pairs plus the number of hit axial layers (0..6). Bit 9 has no effect on any output.
- R5: The bench sees both sums only through the outputs. Over the usable layers, SA = Σ WT_K[i]·angle and SB = Σ WD_K[4i+bin]·angle.
- R6: With index j = 4n+bin, the angle correction is dphi_out = ((((SA·SC_K[j])>>>13) − ((SB·SB_K[j])>>>13)) · DEN_K[j]) >>> 16, truncated to 32 bits.
- R7: The curvature correction is d = ((((SA·SB_K[j])>>>14) − ((SB·SA_K[n])>>>14)) · DEN_K[j]) >>> 16. The output is rho_out = (rho_in << 2) + d, truncated to 32 bits.
- R8: out_ok is 1 exactly when n ≥ 2. When out_ok is 0, dphi_out is 0 and rho_out is rho_in << 2.
- R9: out_done pulses for one cycle, 8 rising edges after the edge that samples in_stb. Strobes on consecutive cycles each give their own result, in order.
- R10: While rst is high and after it is released, out_done stays 0 until a strobe has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | 1 | One-cycle strobe marking a valid seed |
| seg_ang | input | 90 | Nine signed angle words, layer i in bits 10i+9:10i |
| hit_map | input | 10 | Layer hit flags |
| rho_in | input | 6 | Signed first-guess curvature |
| out_done | output | 1 | Result valid pulse |
| out_ok | output | 1 | Enough usable layers for a fit |
| dphi_out | output | 32 | Angle correction |
| rho_out | output | 32 | Refined curvature |

## Verification
The checker assumes in_stb is low while rst is high, and it reads the inputs 8 cycles back only when a done pulse appears. It also assumes the table contents are small enough that no intermediate exceeds its sized width, so the truncating casts lose nothing. The bench keeps inside these limits: its table values are small, strobes start only after reset, and it sweeps all 1024 hit maps and all 64 curvature codes with back-to-back strobes.

// File: rtl/trk_rphi_fit.sv
module trk_rphi_fit #(
  parameter int SEGW = 10,
  parameter int RHOW = 6,
  parameter int TW   = 16,
  parameter int NB   = 4,
  parameter int OW   = 32,
  parameter logic signed [TW-1:0] CONV_K [9]    = '{default: 16'sd8192},
  parameter logic signed [TW-1:0] ZERO_K [9]    = '{default: 16'sd0},
  parameter logic signed [TW-1:0] CURV_K [9*NB] = '{default: 16'sd3},
  parameter logic signed [TW-1:0] WT_K   [9]    = '{default: 16'sd1},
  parameter logic signed [TW-1:0] WD_K   [9*NB] = '{default: 16'sd2},
  parameter logic signed [TW-1:0] SA_K   [7]    = '{default: 16'sd100},
  parameter logic signed [TW-1:0] SB_K   [7*NB] = '{default: 16'sd50},
  parameter logic signed [TW-1:0] SC_K   [7*NB] = '{default: 16'sd70},
  parameter logic signed [TW-1:0] DEN_K  [7*NB] = '{default: 16'sd300}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_stb,
  input  logic [9*SEGW-1:0] seg_ang,
  input  logic [9:0]       hit_map,
  input  logic [RHOW-1:0]  rho_in,
  output logic             out_done,
  output logic             out_ok,
  output logic [OW-1:0]    dphi_out,
  output logic [OW-1:0]    rho_out
);
  localparam int NL    = 9;
  localparam int BB    = $clog2(NB);
  localparam int BINSH = RHOW - 1 - BB;
  localparam int AW    = SEGW + TW;
  localparam int PHW   = ((AW - 13 > TW) ? AW - 13 : TW) + 2;
  localparam int MW    = PHW + TW;
  localparam int SUMW  = MW + 4;
  localparam int QW    = SUMW + TW;
  localparam int DW    = QW - 12;
  localparam int FW    = DW + TW;

  logic [RHOW:0] mag, mag_sh;
  logic [BB-1:0] bin_c;
  logic [NL-1:0] use_c;
  logic [2:0]    cnt_c;

  assign mag    = rho_in[RHOW-1] ? (RHOW+1)'(0) - {1'b1, rho_in} : {1'b0, rho_in};
  assign mag_sh = mag >> BINSH;
  assign bin_c  = (mag_sh > (RHOW+1)'(NB-1)) ? BB'(NB-1) : mag_sh[BB-1:0];

  always_comb begin
    cnt_c = '0;
    for (int p = 0; p < 3; p++) begin
      use_c[2*p]   = hit_map[2*p] & hit_map[2*p+1];
      use_c[2*p+1] = hit_map[2*p] & hit_map[2*p+1];
      cnt_c = cnt_c + 3'(use_c[2*p]);
    end
    for (int a = 6; a < NL; a++) begin
      use_c[a] = hit_map[a];
      cnt_c = cnt_c + 3'(hit_map[a]);
    end
  end

  logic [8:1]                 vld;
  logic [BB-1:0]              bin_q [1:7];
  logic [2:0]                 cnt_q [1:7];
  logic signed [RHOW-1:0]     rho_q [1:7];
  logic [NL-1:0]              use_q [1:2];

  logic signed [AW-1:0]   s1_prod [NL];
  logic signed [PHW-1:0]  s2_phi  [NL];
  logic signed [MW-1:0]   s3_a    [NL];
  logic signed [MW-1:0]   s3_b    [NL];
  logic signed [SUMW-1:0] s4_sa, s4_sb, sa_c, sb_c;
  logic signed [QW-1:0]   s5_p1, s5_p2, s5_p3, s5_p4;
  logic signed [DW-1:0]   s6_d1, s6_d2;
  logic signed [FW-1:0]   s7_f1, s7_f2;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[7:1], in_stb};
  end

  always_ff @(posedge clk) begin
    bin_q[1] <= bin_c;
    cnt_q[1] <= cnt_c;
    rho_q[1] <= $signed(rho_in);
    use_q[1] <= use_c;
    use_q[2] <= use_q[1];
    for (int s = 2; s <= 7; s++) begin
      bin_q[s] <= bin_q[s-1];
      cnt_q[s] <= cnt_q[s-1];
      rho_q[s] <= rho_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++)
      s1_prod[i] <= AW'($signed(seg_ang[i*SEGW +: SEGW])) * AW'(CONV_K[i]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++)
      s2_phi[i] <= PHW'(s1_prod[i] >>> 13) + PHW'(ZERO_K[i])
                 + (rho_q[1] < 0 ? -PHW'(CURV_K[i*NB + int'(bin_q[1])])
                                 :  PHW'(CURV_K[i*NB + int'(bin_q[1])]));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      s3_a[i] <= use_q[2][i] ? MW'(s2_phi[i]) * MW'(WT_K[i]) : '0;
      s3_b[i] <= use_q[2][i] ? MW'(s2_phi[i]) * MW'(WD_K[i*NB + int'(bin_q[2])]) : '0;
    end
  end

  always_comb begin
    sa_c = '0;
    sb_c = '0;
    for (int i = 0; i < NL; i++) begin
      sa_c = sa_c + SUMW'(s3_a[i]);
      sb_c = sb_c + SUMW'(s3_b[i]);
    end
  end

  always_ff @(posedge clk) begin
    s4_sa <= sa_c;
    s4_sb <= sb_c;
  end

  int j4;
  assign j4 = int'(cnt_q[4]) * NB + int'(bin_q[4]);

  always_ff @(posedge clk) begin
    s5_p1 <= QW'(s4_sa) * QW'(SC_K[j4]);
    s5_p2 <= QW'(s4_sb) * QW'(SB_K[j4]);
    s5_p3 <= QW'(s4_sa) * QW'(SB_K[j4]);
    s5_p4 <= QW'(s4_sb) * QW'(SA_K[int'(cnt_q[4])]);
  end

  always_ff @(posedge clk) begin
    s6_d1 <= DW'(s5_p1 >>> 13) - DW'(s5_p2 >>> 13);
    s6_d2 <= DW'(s5_p3 >>> 14) - DW'(s5_p4 >>> 14);
  end

  int j6;
  assign j6 = int'(cnt_q[6]) * NB + int'(bin_q[6]);

  always_ff @(posedge clk) begin
    s7_f1 <= FW'(s6_d1) * FW'(DEN_K[j6]);
    s7_f2 <= FW'(s6_d2) * FW'(DEN_K[j6]);
  end

  logic fit_ok;
  assign fit_ok = cnt_q[7] >= 3'd2;

  always_ff @(posedge clk) begin
    out_ok   <= fit_ok;
    dphi_out <= fit_ok ? OW'(s7_f1 >>> 16) : '0;
    rho_out  <= (OW'(rho_q[7]) <<< 2) + (fit_ok ? OW'(s7_f2 >>> 16) : OW'(0));
  end

  assign out_done = vld[8];
endmodule

// File: rtl/trk_rphi_fit_chk.sv
module trk_rphi_fit_chk #(
  parameter int RHOW = 6,
  parameter int OW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_stb,
  input logic [9:0]      hit_map,
  input logic [RHOW-1:0] rho_in,
  input logic            out_done,
  input logic            out_ok,
  input logic [OW-1:0]   dphi_out,
  input logic [OW-1:0]   rho_out
);
  function automatic int used_cnt(input logic [9:0] h);
    int c = 0;
    for (int p = 0; p < 3; p++) c += int'(h[2*p] & h[2*p+1]);
    for (int a = 6; a < 9; a++) c += int'(h[a]);
    return c;
  endfunction

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_done |-> $past(in_stb, 8)); // R9
  AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    in_stb |-> ##8 out_done); // R9
  AST_NOFIT_DPHI: assert property (@(posedge clk) disable iff (rst)
    (out_done && !out_ok) |-> dphi_out == '0); // R8
  AST_NOFIT_RHO: assert property (@(posedge clk) disable iff (rst)
    (out_done && !out_ok) |-> rho_out == (OW'($signed($past(rho_in, 8))) <<< 2)); // R8
  AST_OK_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_done |-> out_ok == (used_cnt($past(hit_map, 8)) >= 2)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_done); // R10
endmodule

bind trk_rphi_fit trk_rphi_fit_chk #(.RHOW(RHOW), .OW(OW)) chk_i (
  .clk(clk), .rst(rst), .in_stb(in_stb), .hit_map(hit_map), .rho_in(rho_in),
  .out_done(out_done), .out_ok(out_ok), .dphi_out(dphi_out), .rho_out(rho_out)
);

// File: tb/trk_rphi_fit_tb_top.sv
module trk_rphi_fit_tb_top;
  localparam logic signed [15:0] T_CONV [9] = '{8192, 7000, 9100, 8000, 8500, 6000, 8192, 10000, 7600};
  localparam logic signed [15:0] T_ZERO [9] = '{3, -4, 10, 0, -7, 2, 5, -1, 8};
  localparam logic signed [15:0] T_CURV [36] = '{
    1, 4, 9, 15,  2, 5, 11, 17,  -1, 3, 8, 14,  0, 6, 12, 20,  3, 7, 13, 21,
    1, 2, 6, 10,  4, 8, 16, 24,  2, 6, 10, 18,  -2, 1, 5, 9};
  localparam logic signed [15:0] T_WT [9] = '{2, 2, 3, 3, 1, 1, 4, 5, 3};
  localparam logic signed [15:0] T_WD [36] = '{
    1, 2, 3, 4,  -1, 2, 5, 7,  3, 1, 0, -2,  2, 2, 2, 2,  4, 3, 2, 1,
    -3, -1, 1, 3,  5, 6, 7, 8,  1, -2, 3, -4,  2, 4, 6, 8};
  localparam logic signed [15:0] T_SA [7] = '{0, 120, 260, 390, 540, 700, 860};
  localparam logic signed [15:0] T_SB [28] = '{
    0, 0, 0, 0,  40, 45, 50, 55,  60, 66, 71, 80,  90, 95, 101, 110,
    120, 130, 135, 140,  150, 160, 170, 175,  185, 190, 200, 210};
  localparam logic signed [15:0] T_SC [28] = '{
    0, 0, 0, 0,  70, 75, 81, 90,  100, 110, 115, 122,  140, 150, 155, 170,
    190, 200, 205, 220,  230, 245, 255, 260,  280, 290, 300, 315};
  localparam logic signed [15:0] T_DEN [28] = '{
    0, 0, 0, 0,  900, 850, 800, 760,  700, 680, 640, 600,  560, 540, 500, 470,
    450, 430, 410, 390,  370, 350, 330, 310,  300, 290, 280, 270};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_stb = 1'b0;
  logic [89:0] seg_ang = '0;
  logic [9:0] hit_map = '0;
  logic [5:0] rho_in = '0;
  logic out_done, out_ok;
  logic [31:0] dphi_out, rho_out;

  trk_rphi_fit #(
    .CONV_K(T_CONV), .ZERO_K(T_ZERO), .CURV_K(T_CURV), .WT_K(T_WT), .WD_K(T_WD),
    .SA_K(T_SA), .SB_K(T_SB), .SC_K(T_SC), .DEN_K(T_DEN)
  ) dut_i (
    .clk(clk), .rst(rst), .in_stb(in_stb), .seg_ang(seg_ang), .hit_map(hit_map),
    .rho_in(rho_in), .out_done(out_done), .out_ok(out_ok), .dphi_out(dphi_out),
    .rho_out(rho_out)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_sent = 0, n_seen = 0;
  logic        e_ok   [2048];
  logic [31:0] e_dphi [2048];
  logic [31:0] e_rho  [2048];
  int          e_cyc  [2048];
  logic [31:0] r_dphi [2048];
  logic [31:0] r_rho  [2048];
  bit sending_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit good, input string req, input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [89:0] sg, input logic [9:0] hm, input logic [5:0] ri,
                                output logic ok, output logic [31:0] dp, output logic [31:0] ro);
    longint rho, mag, bin, sa, sb, seg, phi, d1, d2, f1, f2, idx, cv;
    int cnt;
    logic [8:0] u;
    rho = longint'($signed(ri));
    mag = rho < 0 ? -rho : rho;
    bin = mag >> 3;
    if (bin > 3) bin = 3;
    cnt = 0;
    for (int p = 0; p < 3; p++) begin
      u[2*p] = hm[2*p] & hm[2*p+1];
      u[2*p+1] = u[2*p];
      cnt += int'(u[2*p]);
    end
    for (int a = 6; a < 9; a++) begin
      u[a] = hm[a];
      cnt += int'(hm[a]);
    end
    sa = 0; sb = 0;
    for (int i = 0; i < 9; i++) begin
      seg = longint'($signed(sg[i*10 +: 10]));
      cv = longint'(T_CURV[i*4 + int'(bin)]);
      phi = ((seg * longint'(T_CONV[i])) >>> 13) + longint'(T_ZERO[i]) + (rho < 0 ? -cv : cv);
      if (u[i]) begin
        sa += phi * longint'(T_WT[i]);
        sb += phi * longint'(T_WD[i*4 + int'(bin)]);
      end
    end
    idx = longint'(cnt) * 4 + bin;
    d1 = ((sa * longint'(T_SC[idx])) >>> 13) - ((sb * longint'(T_SB[idx])) >>> 13);
    d2 = ((sa * longint'(T_SB[idx])) >>> 14) - ((sb * longint'(T_SA[cnt])) >>> 14);
    f1 = (d1 * longint'(T_DEN[idx])) >>> 16;
    f2 = (d2 * longint'(T_DEN[idx])) >>> 16;
    ok = cnt >= 2;
    dp = ok ? f1[31:0] : 32'd0;
    ro = 32'(rho * 4 + (ok ? f2 : 0));
  endfunction

  task automatic send(input logic [89:0] sg, input logic [9:0] hm, input logic [5:0] ri);
    @(negedge clk);
    seg_ang = sg; hit_map = hm; rho_in = ri; in_stb = 1'b1;
    model(sg, hm, ri, e_ok[n_sent], e_dphi[n_sent], e_rho[n_sent]);
    e_cyc[n_sent] = cyc + 8;
    n_sent++;
  endtask

  function automatic logic [89:0] mk_seg(input int k);
    logic [89:0] v;
    for (int i = 0; i < 9; i++) v[i*10 +: 10] = 10'((k * 37 + i * 101 + 5) % 1024);
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && out_done) begin
      if (n_seen < n_sent) begin
        check(cyc == e_cyc[n_seen], "R9 latency", cyc, e_cyc[n_seen]);
        check(out_ok == e_ok[n_seen], "R4 R8 ok", out_ok, e_ok[n_seen]);
        check(dphi_out == e_dphi[n_seen], "R1 R2 R3 R5 R6 dphi",
              longint'($signed(dphi_out)), longint'($signed(e_dphi[n_seen])));
        check(rho_out == e_rho[n_seen], "R5 R7 R8 rho",
              longint'($signed(rho_out)), longint'($signed(e_rho[n_seen])));
        r_dphi[n_seen] = dphi_out;
        r_rho[n_seen] = rho_out;
      end else begin
        check(1'b0, "R9 extra done", 1, 0);
      end
      n_seen++;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(out_done == 1'b0, "R10 done in reset", out_done, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(out_done == 1'b0, "R10 done idle", out_done, 0);
    for (int k = 0; k < 1024; k++) send(mk_seg(k), 10'(k), 6'((k * 7) % 64));
    for (int r = 0; r < 64; r++) send(mk_seg(r + 3000), 10'h1FF, 6'(r));
    base = n_sent;
    send(mk_seg(77), 10'h0CF, 6'd45);
    send(mk_seg(77), 10'h2CF, 6'd45);
    @(negedge clk);
    in_stb = 1'b0;
    for (int k = 0; k < 5; k++) begin
      send(mk_seg(k + 500), 10'h3FF, 6'(k * 13));
      @(negedge clk);
      in_stb = 1'b0;
      repeat (k) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(n_seen == n_sent, "R9 done count", n_seen, n_sent);
    check(r_dphi[base] == r_dphi[base+1] && r_rho[base] == r_rho[base+1], "R4 bit9 ignored",
          longint'($signed(r_dphi[base+1])), longint'($signed(r_dphi[base])));
    sending_done = 1'b1;
  end

  initial begin
    int wd = 0;
    while (!sending_done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!sending_done) check(1'b0, "watchdog", wd, 100000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule